// File: doc/BRIEF.md
# Parallel Deadlock Detection Matrix Engine

This block decides whether a set of processes sharing single-instance resources has reached deadlock. The resource-allocation graph is kept as a matrix with one row per resource and one column per process. Each cell holds one of three codes: no edge, a request edge (the process waits for the resource), or a grant edge (the process holds the resource). Software fills and inspects the matrix through a cell access port, then pulses `start`.

On start the engine copies the stored matrix into a private working matrix, so the allocation state survives the run. In every clock cycle it finds all terminal rows and all terminal columns at once. A line is terminal when its non-empty cells are of one kind only. All edges lying on any terminal line are removed together. The loop ends on the first cycle that would remove nothing, which includes an empty matrix. A one-cycle `done` pulse then reports whether any edge survived (`deadlock`) and how many removing steps ran (`steps`).

The access port is valid/ready. A transfer happens on a rising edge where `acc_valid` and `acc_ready` are both high. The master must hold its request stable until that edge. `acc_ready` is low for the whole of a detection run, which stalls access until the run ends. A read answers one cycle after acceptance with a single-cycle `rsp_valid`. The response has no back-pressure, so the requester must always be able to take it.

Top module: `ddm_engine`

## Requirements
- R1: A write stores a 2-bit cell code in which bit 0 marks a request and bit 1 marks a grant, and 00 means no edge. A read returns the stored code on `rsp_data` with `rsp_valid` high in the cycle after the transfer is accepted.
- R2: A write whose code is 11 is rejected, and the addressed cell keeps its previous code.
- R3: `acc_ready` is low while `busy` is high. An access presented during a run has no effect. A `start` pulse during a run is ignored.
- R4: In one step, every edge in a column whose edges are all requests or all grants is removed.
- R5: In the same step, every edge in a row whose edges are all requests or all grants is removed.
- R6: Each step takes one clock cycle, and reduction stops on the first cycle that removes nothing. `done` rises exactly steps+1 cycles after the edge that accepts `start`, and it stays high for a single cycle.
- R7: `deadlock` is 1 at `done` exactly when at least one edge remains in the working matrix.
- R8: `steps` counts the cycles that removed at least one edge. It saturates at 2·min(rows, columns) − 3, or at 1 when that value is below 1.
- R9: A matrix whose edges occupy fewer than two rows, or fewer than two columns, never reports deadlock.
- R10: A run does not change the stored matrix. Starting again on the same matrix gives the same result.
- R11: After reset, every cell is empty, `acc_ready` is 1, and `busy`, `done`, `deadlock`, `steps` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Cell access request valid |
| acc_ready | output | 1 | Cell access can be accepted (idle) |
| acc_write | input | 1 | 1 = write cell, 0 = read cell |
| acc_row | input | ROW_W (2) | Resource index |
| acc_col | input | COL_W (2) | Process index |
| acc_wdata | input | 2 | Cell code to write: bit 0 request, bit 1 grant |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_data | output | 2 | Cell code read |
| start | input | 1 | Begin a detection run (ignored while busy) |
| busy | output | 1 | Detection run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| deadlock | output | 1 | Edges remained at the end of the last run |
| steps | output | STEP_W (3) | Removing steps in the last run |

## Verification
The bench targets graphs in which reduction needs several cascaded steps. One example is a three-link chain that empties in three steps. An engine that removed only rows, only columns, or one line per cycle would report a wrong step count or a false deadlock there. Cycles of two and three processes are checked with and without a removable tail. A design that treated a mixed line as terminal would miss these deadlocks, and one that never removed the tail would miscount the steps. Matrices with a single populated row or column check that a lone line is always fully reducible. The remaining cases are accesses and `start` pulses issued while a run is active, a code-11 write, and a repeated run on the same matrix, which exposes a destructive reduction.

// File: rtl/ddm_pkg.sv
package ddm_pkg;

  typedef enum logic [1:0] {
    CELL_NONE = 2'b00,
    CELL_REQ  = 2'b01,
    CELL_GNT  = 2'b10,
    CELL_BAD  = 2'b11
  } cell_e;

  function automatic int min_of(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int step_limit(input int rows, input int cols);
    int lim;
    lim = 2 * min_of(rows, cols) - 3;
    return (lim < 1) ? 1 : lim;
  endfunction

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/ddm_cell_store.sv
module ddm_cell_store
  import ddm_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int ROW_W = 2,
  parameter int COL_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_fire,
  input  logic                      acc_write,
  input  logic [ROW_W-1:0]          acc_row,
  input  logic [COL_W-1:0]          acc_col,
  input  logic [1:0]                acc_wdata,
  output logic [ROWS-1:0][COLS-1:0] req_m,
  output logic [ROWS-1:0][COLS-1:0] gnt_m,
  output logic                      rsp_valid,
  output logic [1:0]                rsp_data
);

  logic wr_ok;
  assign wr_ok = acc_fire && acc_write && (cell_e'(acc_wdata) != CELL_BAD);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic hit;
      assign hit = wr_ok && (acc_row == ROW_W'(r)) && (acc_col == COL_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req_m[r][c] <= 1'b0;
          gnt_m[r][c] <= 1'b0;
        end else if (hit) begin
          req_m[r][c] <= acc_wdata[0];
          gnt_m[r][c] <= acc_wdata[1];
        end
      end
    end
  end

  logic [1:0] rd_code;
  always_comb begin
    rd_code = 2'b00;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (acc_row == ROW_W'(r) && acc_col == COL_W'(c)) begin
          rd_code = {gnt_m[r][c], req_m[r][c]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 2'b00;
    end else begin
      rsp_valid <= acc_fire && !acc_write;
      if (acc_fire && !acc_write) begin
        rsp_data <= rd_code;
      end
    end
  end

  AST_BAD_CODE_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_write && acc_wdata == 2'b11) |=>
      (req_m == $past(req_m) && gnt_m == $past(gnt_m))); // R2

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !acc_write) |=> rsp_valid); // R1

endmodule

// File: rtl/ddm_term_detect.sv
module ddm_term_detect #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic [ROWS-1:0][COLS-1:0] req_m,
  input  logic [ROWS-1:0][COLS-1:0] gnt_m,
  output logic [ROWS-1:0][COLS-1:0] rem_m,
  output logic [ROWS-1:0]           row_any,
  output logic [COLS-1:0]           col_any,
  output logic                      any_rem
);

  logic [ROWS-1:0] row_term;
  logic [COLS-1:0] col_term;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic has_r, has_g;
    assign has_r       = |req_m[r];
    assign has_g       = |gnt_m[r];
    assign row_any[r]  = has_r | has_g;
    assign row_term[r] = !(has_r && has_g);
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic has_r, has_g;
    always_comb begin
      has_r = 1'b0;
      has_g = 1'b0;
      for (int r = 0; r < ROWS; r++) begin
        has_r = has_r | req_m[r][c];
        has_g = has_g | gnt_m[r][c];
      end
    end
    assign col_any[c]  = has_r | has_g;
    assign col_term[c] = !(has_r && has_g);
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_rem_r
    for (genvar c = 0; c < COLS; c++) begin : g_rem_c
      assign rem_m[r][c] = (req_m[r][c] | gnt_m[r][c]) & (row_term[r] | col_term[c]);
    end
  end

  assign any_rem = |rem_m;

endmodule

// File: rtl/ddm_reduce_ctrl.sv
module ddm_reduce_ctrl #(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int STEP_LIMIT = 5,
  parameter int STEP_W     = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_ok,
  input  logic [ROWS-1:0][COLS-1:0] src_req,
  input  logic [ROWS-1:0][COLS-1:0] src_gnt,
  input  logic [ROWS-1:0][COLS-1:0] rem_m,
  input  logic                      any_rem,
  output logic [ROWS-1:0][COLS-1:0] work_req,
  output logic [ROWS-1:0][COLS-1:0] work_gnt,
  output logic                      busy,
  output logic                      done,
  output logic                      deadlock,
  output logic [STEP_W-1:0]         steps
);

  localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(STEP_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_req <= '0;
      work_gnt <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      deadlock <= 1'b0;
      steps    <= '0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        work_req <= src_req;
        work_gnt <= src_gnt;
        busy     <= 1'b1;
        deadlock <= 1'b0;
        steps    <= '0;
      end else if (busy) begin
        if (any_rem) begin
          work_req <= work_req & ~rem_m;
          work_gnt <= work_gnt & ~rem_m;
          if (steps != STEP_MAX) begin
            steps <= steps + 1'b1;
          end
        end else begin
          busy     <= 1'b0;
          done     <= 1'b1;
          deadlock <= |(work_req | work_gnt);
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    steps <= STEP_MAX); // R8

  AST_WORK_ONLY_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (((work_req & ~$past(work_req)) == '0) &&
              ((work_gnt & ~$past(work_gnt)) == '0))); // R4

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6

endmodule

// File: rtl/ddm_engine.sv
module ddm_engine
  import ddm_pkg::*;
#(
  parameter int NUM_RES  = 4,
  parameter int NUM_PROC = 4,
  localparam int ROW_W      = idx_width(NUM_RES),
  localparam int COL_W      = idx_width(NUM_PROC),
  localparam int STEP_LIMIT = step_limit(NUM_RES, NUM_PROC),
  localparam int STEP_W     = $clog2(STEP_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic [COL_W-1:0]  acc_col,
  input  logic [1:0]        acc_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              deadlock,
  output logic [STEP_W-1:0] steps
);

  logic [NUM_RES-1:0][NUM_PROC-1:0] st_req, st_gnt;
  logic [NUM_RES-1:0][NUM_PROC-1:0] wk_req, wk_gnt, rem_m;
  logic [NUM_RES-1:0]               row_any;
  logic [NUM_PROC-1:0]              col_any;
  logic                             any_rem;
  logic                             acc_fire, start_ok;

  assign acc_ready = !busy;
  assign acc_fire  = acc_valid && acc_ready;
  assign start_ok  = start && !busy;

  ddm_cell_store #(
    .ROWS(NUM_RES), .COLS(NUM_PROC), .ROW_W(ROW_W), .COL_W(COL_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .acc_write(acc_write),
    .acc_row(acc_row), .acc_col(acc_col), .acc_wdata(acc_wdata),
    .req_m(st_req), .gnt_m(st_gnt), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  ddm_term_detect #(
    .ROWS(NUM_RES), .COLS(NUM_PROC)
  ) detect_i (
    .req_m(wk_req), .gnt_m(wk_gnt), .rem_m(rem_m),
    .row_any(row_any), .col_any(col_any), .any_rem(any_rem)
  );

  ddm_reduce_ctrl #(
    .ROWS(NUM_RES), .COLS(NUM_PROC), .STEP_LIMIT(STEP_LIMIT), .STEP_W(STEP_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok),
    .src_req(st_req), .src_gnt(st_gnt), .rem_m(rem_m), .any_rem(any_rem),
    .work_req(wk_req), .work_gnt(wk_gnt), .busy(busy), .done(done),
    .deadlock(deadlock), .steps(steps)
  );

  AST_STORE_HELD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (st_req == $past(st_req) && st_gnt == $past(st_gnt))); // R10

  AST_NO_ACCESS_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !acc_ready); // R3

  AST_DL_NEEDS_TWO_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && deadlock) |-> ($countones(row_any) >= 2 && $countones(col_any) >= 2)); // R9

  AST_DL_MATCHES_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (deadlock == (|row_any))); // R7

endmodule

// File: tb/ddm_engine_tb_top.sv
module ddm_engine_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] req;
    logic [15:0] gnt;
    logic [7:0]  stp;
    logic        dl;
  } vec_t;

  // bit index = resource*4 + process
  localparam vec_t VECS [0:7] = '{
    '{16'h0000, 16'h0000, 8'd0, 1'b0},  // empty
    '{16'h0012, 16'h0021, 8'd0, 1'b1},  // two-process cycle
    '{16'h0010, 16'h0021, 8'd2, 1'b0},  // short chain
    '{16'h0016, 16'h0021, 8'd1, 1'b1},  // cycle plus removable tail
    '{16'h0210, 16'h0421, 8'd3, 1'b0},  // long chain, cascaded steps
    '{16'h0214, 16'h0421, 8'd0, 1'b1},  // three-process cycle
    '{16'hE000, 16'h1000, 8'd1, 1'b0},  // single populated row
    '{16'h0880, 16'h0008, 8'd1, 1'b0}   // single populated column
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_ready;
  logic       acc_write = 1'b0;
  logic [1:0] acc_row = '0;
  logic [1:0] acc_col = '0;
  logic [1:0] acc_wdata = '0;
  logic       rsp_valid;
  logic [1:0] rsp_data;
  logic       start = 1'b0;
  logic       busy, done, deadlock;
  logic [2:0] steps;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddm_engine dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_row(acc_row), .acc_col(acc_col),
    .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .start(start), .busy(busy), .done(done), .deadlock(deadlock), .steps(steps)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int r, input int c, input logic [1:0] d);
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_row   = 2'(r);
    acc_col   = 2'(c);
    acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic read_chk(input int r, input int c, input logic [1:0] exp, input string tag);
    access(1'b0, r, c, 2'b00);
    check(rsp_valid == 1'b1, tag, int'(rsp_valid), 1);
    check(rsp_data == exp, tag, int'(rsp_data), int'(exp));
  endtask

  task automatic load(input logic [15:0] rq, input logic [15:0] gt);
    for (int i = 0; i < 16; i++) begin
      access(1'b1, i / 4, i % 4, {gt[i], rq[i]});
    end
  endtask

  task automatic run(output int st, output bit dl, output int lat);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    st = int'(steps);
    dl = deadlock;
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int st, lat;
    bit dl;

    repeat (3) @(negedge clk);
    // R11 reset state
    check(acc_ready == 1'b1, "R11 ready", int'(acc_ready), 1);
    check(busy == 1'b0, "R11 busy", int'(busy), 0);
    check(done == 1'b0, "R11 done", int'(done), 0);
    check(deadlock == 1'b0, "R11 deadlock", int'(deadlock), 0);
    check(steps == 3'd0, "R11 steps", int'(steps), 0);
    check(rsp_valid == 1'b0, "R11 rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_chk(2, 1, 2'b00, "R11 cell empty");

    // table of graphs: R4 R5 R7 R8 R6 R9
    for (int v = 0; v < 8; v++) begin
      load(VECS[v].req, VECS[v].gnt);
      run(st, dl, lat);
      check(dl == VECS[v].dl, "R7 deadlock flag", int'(dl), int'(VECS[v].dl));
      check(st == int'(VECS[v].stp), "R8 R4 R5 step count", st, int'(VECS[v].stp));
      check(lat == st + 1, "R6 done latency", lat, st + 1);
      if (v >= 6) check(dl == 1'b0, "R9 single line never deadlocks", int'(dl), 0);
    end

    // R1 and R2: code 11 rejected
    load(16'h0000, 16'h0000);
    access(1'b1, 2, 2, 2'b10);
    read_chk(2, 2, 2'b10, "R1 grant stored");
    access(1'b1, 1, 3, 2'b01);
    read_chk(1, 3, 2'b01, "R1 request stored");
    access(1'b1, 2, 2, 2'b11);
    read_chk(2, 2, 2'b10, "R2 bad code keeps grant");
    access(1'b1, 2, 3, 2'b11);
    read_chk(2, 3, 2'b00, "R2 bad code keeps empty");

    // R10 non-destructive run
    load(VECS[1].req, VECS[1].gnt);
    run(st, dl, lat);
    read_chk(0, 0, 2'b10, "R10 grant survives run");
    read_chk(0, 1, 2'b01, "R10 request survives run");
    run(st, dl, lat);
    check(dl == 1'b1, "R10 rerun deadlock", int'(dl), 1);
    check(st == 0, "R10 rerun steps", st, 0);

    // R3 start and access during a run are ignored
    load(VECS[4].req, VECS[4].gnt);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    check(acc_ready == 1'b0, "R3 ready low while busy", int'(acc_ready), 0);
    acc_valid = 1'b1;
    acc_write = 1'b1;
    acc_row   = 2'd3;
    acc_col   = 2'd3;
    acc_wdata = 2'b10;
    lat = 0;
    @(negedge clk);
    lat++;
    start = 1'b0;
    acc_valid = 1'b0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 4, "R3 restart ignored latency", lat, 4);
    check(int'(steps) == 3, "R3 restart ignored steps", int'(steps), 3);
    check(deadlock == 1'b0, "R3 restart ignored flag", int'(deadlock), 0);
    read_chk(3, 3, 2'b00, "R3 write during run dropped");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule